// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block is a 32-pin general-purpose I/O port that a processor controls over a simple register bus. Two registers set the pin state. The direction register decides whether each pad drives or floats. The level register gives the value driven on each output pad. Each of these two registers also has alias addresses that set, clear or toggle the bits written with 1 and leave every other pin alone, so software can change one pin without a read-modify-write.

Each pin also has its own configuration word. It holds an input-buffer enable and a peripheral override enable, plus a 4-bit function select. While the override is on, the pad takes its level and its enable from one of sixteen peripheral signal pairs. The port's own direction and level for that pin then have no effect.

The bus takes at most one write per clock, and reads are combinational from the address. After reset every pad floats, every input buffer is off and every pin belongs to the port.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register, the level register and every configuration word read 0, `pad_oe` is all zeros and `pad_ie` is all zeros.
- R2: A write to byte address 0x00 loads the whole direction register, and a read of 0x00 returns it.
- R3: A write to 0x08 sets the direction bits written with 1. A write to 0x04 clears the direction bits written with 1. In both cases the bits written with 0 keep their value.
- R4: A write to 0x0C loads the whole level register. Writes to 0x14, 0x10 and 0x18 set, clear or invert the level bits written with 1, and the bits written with 0 keep their value.
- R5: Reads of the alias addresses 0x04 and 0x08 return the direction register. Reads of 0x10, 0x14 and 0x18 return the level register. A read of any unmapped address returns 0.
- R6: For a pin whose override is off, `pad_oe` equals its direction bit and `pad_out` equals its level bit.
- R7: Pin y has a configuration word at byte address 0x80 + 4*y. In that word, bit 0 is the input enable, bit 1 is the override enable and bits 7:4 are the function select. All other bits read 0. Bit 0 drives `pad_ie[y]`, and a write to the word of one pin leaves the words of all other pins unchanged.
- R8: For a pin y whose override is on with select f, `pad_out[y]` equals `per_out[f*32+y]` and `pad_oe[y]` equals `per_oe[f*32+y]`. The port's direction and level bits for that pin have no effect on the pad.
- R9: While `bus_wr` is low, no register changes, whatever the address and data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| per_out | input | 512 | Peripheral output levels, function f pin y at bit f*32+y |
| per_oe | input | 512 | Peripheral output enables, same layout |
| pad_out | output | 32 | Level driven to each pad |
| pad_oe | output | 32 | Output-driver enable of each pad |
| pad_ie | output | 32 | Input-buffer enable of each pad |

## Verification
The hardest case to reach from the ports is an override pin whose port settings disagree with the peripheral pair, because only then does the pad show that the port bits have no effect. The stimulus first makes that pin a port input driving 0. It then enables the override and selects a function whose pair drives high with the driver on. Next it switches to a function whose pair is all zeros, and finally it drops the override to confirm that the port values come back unchanged. Neighbouring pins are kept on port control throughout, and the bench watches them to catch a select that decodes to the wrong pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_DIR     = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIR_CLR = 8'h04;
  localparam logic [ADDR_W-1:0] A_DIR_SET = 8'h08;
  localparam logic [ADDR_W-1:0] A_LVL     = 8'h0C;
  localparam logic [ADDR_W-1:0] A_LVL_CLR = 8'h10;
  localparam logic [ADDR_W-1:0] A_LVL_SET = 8'h14;
  localparam logic [ADDR_W-1:0] A_LVL_TGL = 8'h18;
  localparam logic [ADDR_W-1:0] A_CFG_BASE = 8'h80;

  // configuration word field positions
  localparam int CF_IE  = 0;
  localparam int CF_MUX = 1;
  localparam int CF_SEL = 4;

  typedef enum logic [2:0] {
    RK_NONE, RK_DIR, RK_DIR_CLR, RK_DIR_SET,
    RK_LVL, RK_LVL_CLR, RK_LVL_SET, RK_LVL_TGL
  } reg_kind_e;

  function automatic reg_kind_e decode_kind(input logic [ADDR_W-1:0] a);
    case (a)
      A_DIR:     return RK_DIR;
      A_DIR_CLR: return RK_DIR_CLR;
      A_DIR_SET: return RK_DIR_SET;
      A_LVL:     return RK_LVL;
      A_LVL_CLR: return RK_LVL_CLR;
      A_LVL_SET: return RK_LVL_SET;
      A_LVL_TGL: return RK_LVL_TGL;
      default:   return RK_NONE;
    endcase
  endfunction

  // word-aligned and inside the configuration window
  function automatic logic is_cfg_addr(input logic [ADDR_W-1:0] a, input int npin);
    int off;
    off = int'(a) - int'(A_CFG_BASE);
    return (a[1:0] == 2'b00) && (off >= 0) && (off < 4 * npin);
  endfunction
endpackage

// File: rtl/gpio_dirlvl_bank.sv
module gpio_dirlvl_bank #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_dir_ld,
  input  logic            ev_dir_set,
  input  logic            ev_dir_clr,
  input  logic            ev_lvl_ld,
  input  logic            ev_lvl_set,
  input  logic            ev_lvl_clr,
  input  logic            ev_lvl_tgl,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] lvl_q
);
  // load takes the whole word; otherwise set, then clear (clear wins), then toggle
  function automatic logic [NPIN-1:0] step_bits(
    input logic [NPIN-1:0] cur,
    input logic [NPIN-1:0] d,
    input logic ld, input logic set, input logic clr, input logic tgl);
    logic [NPIN-1:0] r;
    if (ld) return d;
    r = cur;
    if (set) r = r | d;
    if (clr) r = r & ~d;
    if (tgl) r = r ^ d;
    return r;
  endfunction

  logic [NPIN-1:0] dir_d, lvl_d;

  always_comb begin
    dir_d = step_bits(dir_q, wdata, ev_dir_ld, ev_dir_set, ev_dir_clr, 1'b0);
    lvl_d = step_bits(lvl_q, wdata, ev_lvl_ld, ev_lvl_set, ev_lvl_clr, ev_lvl_tgl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
  parameter int NPIN  = 32,
  parameter int SEL_W = 4,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [$clog2(NPIN)-1:0] cfg_idx,
  input  logic                  d_ie,
  input  logic                  d_mux,
  input  logic [SEL_W-1:0]      d_sel,
  output logic [NPIN-1:0]       ie_q,
  output logic [NPIN-1:0]       mux_q,
  output logic [NPIN*SEL_W-1:0] sel_q,
  output logic [DW-1:0]         cfg_rdata
);
  import gpio_port_pkg::*;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic hit;
    assign hit = cfg_wr && (cfg_idx == p[$clog2(NPIN)-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ie_q[p]               <= 1'b0;
        mux_q[p]              <= 1'b0;
        sel_q[p*SEL_W +: SEL_W] <= '0;
      end else if (hit) begin
        ie_q[p]               <= d_ie;
        mux_q[p]              <= d_mux;
        sel_q[p*SEL_W +: SEL_W] <= d_sel;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[CF_IE]              = ie_q[cfg_idx];
    cfg_rdata[CF_MUX]             = mux_q[cfg_idx];
    cfg_rdata[CF_SEL +: SEL_W]    = sel_q[cfg_idx*SEL_W +: SEL_W];
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NPIN  = 32,
  parameter int NFUNC = 16,
  parameter int SEL_W = 4
) (
  input  logic [NPIN-1:0]       dir_q,
  input  logic [NPIN-1:0]       lvl_q,
  input  logic [NPIN-1:0]       mux_q,
  input  logic [NPIN*SEL_W-1:0] sel_q,
  input  logic [NFUNC*NPIN-1:0] per_out,
  input  logic [NFUNC*NPIN-1:0] per_oe,
  output logic [NPIN-1:0]       pad_out,
  output logic [NPIN-1:0]       pad_oe
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [NFUNC-1:0] col_o, col_e;
    logic [SEL_W-1:0] s;
    logic             pick_o, pick_e;
    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      assign col_o[f] = per_out[f*NPIN + p];
      assign col_e[f] = per_oe[f*NPIN + p];
    end
    assign s = sel_q[p*SEL_W +: SEL_W];
    always_comb begin
      pick_o = 1'b0;
      pick_e = 1'b0;
      if (int'(s) < NFUNC) begin
        pick_o = col_o[s];
        pick_e = col_e[s];
      end
    end
    assign pad_out[p] = mux_q[p] ? pick_o : lvl_q[p];
    assign pad_oe[p]  = mux_q[p] ? pick_e : dir_q[p];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int NPIN  = 32,
  parameter int NFUNC = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [NPIN-1:0]       bus_wdata,
  output logic [NPIN-1:0]       bus_rdata,
  input  logic [NFUNC*NPIN-1:0] per_out,
  input  logic [NFUNC*NPIN-1:0] per_oe,
  output logic [NPIN-1:0]       pad_out,
  output logic [NPIN-1:0]       pad_oe,
  output logic [NPIN-1:0]       pad_ie
);
  import gpio_port_pkg::*;

  localparam int SEL_W = $clog2(NFUNC);
  localparam int PIN_W = $clog2(NPIN);

  reg_kind_e kind;
  logic      cfg_hit;
  logic      ev_dir_ld, ev_dir_set, ev_dir_clr;
  logic      ev_lvl_ld, ev_lvl_set, ev_lvl_clr, ev_lvl_tgl, ev_cfg_wr;
  logic [NPIN-1:0]       dir_q, lvl_q, ie_q, mux_q;
  logic [NPIN*SEL_W-1:0] sel_q;
  logic [NPIN-1:0]       cfg_rdata;
  logic [PIN_W-1:0]      cfg_idx;

  assign kind    = decode_kind(bus_addr);
  assign cfg_hit = is_cfg_addr(bus_addr, NPIN);
  assign cfg_idx = bus_addr[PIN_W+1:2];

  // named write events
  assign ev_dir_ld  = bus_wr && (kind == RK_DIR);
  assign ev_dir_set = bus_wr && (kind == RK_DIR_SET);
  assign ev_dir_clr = bus_wr && (kind == RK_DIR_CLR);
  assign ev_lvl_ld  = bus_wr && (kind == RK_LVL);
  assign ev_lvl_set = bus_wr && (kind == RK_LVL_SET);
  assign ev_lvl_clr = bus_wr && (kind == RK_LVL_CLR);
  assign ev_lvl_tgl = bus_wr && (kind == RK_LVL_TGL);
  assign ev_cfg_wr  = bus_wr && cfg_hit;

  gpio_dirlvl_bank #(.NPIN(NPIN)) u_dirlvl (
    .clk(clk), .rst_n(rst_n),
    .ev_dir_ld(ev_dir_ld), .ev_dir_set(ev_dir_set), .ev_dir_clr(ev_dir_clr),
    .ev_lvl_ld(ev_lvl_ld), .ev_lvl_set(ev_lvl_set), .ev_lvl_clr(ev_lvl_clr),
    .ev_lvl_tgl(ev_lvl_tgl),
    .wdata(bus_wdata), .dir_q(dir_q), .lvl_q(lvl_q)
  );

  gpio_cfg_bank #(.NPIN(NPIN), .SEL_W(SEL_W), .DW(NPIN)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(ev_cfg_wr), .cfg_idx(cfg_idx),
    .d_ie(bus_wdata[CF_IE]), .d_mux(bus_wdata[CF_MUX]),
    .d_sel(bus_wdata[CF_SEL +: SEL_W]),
    .ie_q(ie_q), .mux_q(mux_q), .sel_q(sel_q), .cfg_rdata(cfg_rdata)
  );

  gpio_pad_mux #(.NPIN(NPIN), .NFUNC(NFUNC), .SEL_W(SEL_W)) u_mux (
    .dir_q(dir_q), .lvl_q(lvl_q), .mux_q(mux_q), .sel_q(sel_q),
    .per_out(per_out), .per_oe(per_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pad_ie = ie_q;

  always_comb begin
    case (kind)
      RK_DIR, RK_DIR_CLR, RK_DIR_SET:             bus_rdata = dir_q;
      RK_LVL, RK_LVL_CLR, RK_LVL_SET, RK_LVL_TGL: bus_rdata = lvl_q;
      default: bus_rdata = cfg_hit ? cfg_rdata : '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [NPIN-1:0] bus_wdata,
  input logic            ev_dir_set,
  input logic            ev_dir_clr,
  input logic            ev_lvl_tgl,
  input logic [NPIN-1:0] dir_q,
  input logic [NPIN-1:0] lvl_q,
  input logic [NPIN-1:0] mux_q,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_out
);
  // R3
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_set |=> dir_q == ($past(dir_q) | $past(bus_wdata)));
  // R3
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_clr |=> dir_q == ($past(dir_q) & ~$past(bus_wdata)));
  // R4
  lvl_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lvl_tgl |=> lvl_q == ($past(lvl_q) ^ $past(bus_wdata)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(dir_q) && $stable(lvl_q) && $stable(mux_q)));
  // R6
  port_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & ~mux_q) == '0);
  // R6
  port_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ lvl_q) & ~mux_q) == '0);
endmodule

bind gpio_port gpio_port_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .ev_dir_set(ev_dir_set), .ev_dir_clr(ev_dir_clr), .ev_lvl_tgl(ev_lvl_tgl),
  .dir_q(dir_q), .lvl_q(lvl_q), .mux_q(mux_q),
  .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int NPIN = 32;
  localparam int NFUNC = 16;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [NPIN-1:0] bus_wdata = 0, bus_rdata;
  logic [NFUNC*NPIN-1:0] per_out = 0, per_oe = 0;
  logic [NPIN-1:0] pad_out, pad_oe, pad_ie;

  int n_chk = 0, n_bad = 0;
  logic [NPIN-1:0] dir_m = 0, lvl_m = 0;

  always #2 clk = ~clk;

  gpio_port #(.NPIN(NPIN), .NFUNC(NFUNC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_out(per_out),
    .per_oe(per_oe), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check("R1 dir", v, 0);
    rd(8'h0C, v); check("R1 lvl", v, 0);
    rd(8'h80, v); check("R1 cfg0", v, 0);
    rd(8'hFC, v); check("R1 cfg31", v, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 pad_ie", pad_ie, 0);
  endtask

  task automatic t_dir;
    logic [31:0] v;
    dir_m = 32'hA5A5_F00F; wr(8'h00, dir_m);
    rd(8'h00, v); check("R2 dir load", v, dir_m);
    check("R6 oe follows dir", pad_oe, dir_m);
    wr(8'h08, 32'h0000_FF00); dir_m |= 32'h0000_FF00;
    rd(8'h00, v); check("R3 dirset", v, dir_m);
    wr(8'h04, 32'h8000_000F); dir_m &= ~32'h8000_000F;
    rd(8'h00, v); check("R3 dirclr", v, dir_m);
    rd(8'h04, v); check("R5 dirclr reads dir", v, dir_m);
    rd(8'h08, v); check("R5 dirset reads dir", v, dir_m);
  endtask

  task automatic t_lvl;
    logic [31:0] v;
    lvl_m = 32'h1234_5678; wr(8'h0C, lvl_m);
    rd(8'h0C, v); check("R4 lvl load", v, lvl_m);
    wr(8'h14, 32'hF000_0001); lvl_m |= 32'hF000_0001;
    rd(8'h0C, v); check("R4 lvlset", v, lvl_m);
    wr(8'h10, 32'h0000_0078); lvl_m &= ~32'h0000_0078;
    rd(8'h0C, v); check("R4 lvlclr", v, lvl_m);
    wr(8'h18, 32'hFFFF_0000); lvl_m ^= 32'hFFFF_0000;
    rd(8'h18, v); check("R4 R5 lvltgl via alias", v, lvl_m);
    wr(8'h18, 32'hFFFF_0000); lvl_m ^= 32'hFFFF_0000;
    rd(8'h10, v); check("R5 lvlclr reads lvl", v, lvl_m);
    rd(8'h14, v); check("R5 lvlset reads lvl", v, lvl_m);
    check("R6 pad_out follows lvl", pad_out, lvl_m);
    rd(8'h40, v); check("R5 unmapped", v, 0);
  endtask

  task automatic t_idle;
    logic [31:0] v;
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    bus_addr = 8'h18;
    repeat (3) @(negedge clk);
    rd(8'h00, v); check("R9 dir held", v, dir_m);
    rd(8'h0C, v); check("R9 lvl held", v, lvl_m);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr(8'h80 + 8'd20, 32'h0000_0031);
    rd(8'h94, v); check("R7 cfg5 readback", v, 32'h31);
    check("R7 pad_ie", pad_ie, 32'h0000_0020);
    rd(8'h98, v); check("R7 cfg6 untouched", v, 0);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, v); check("R7 cfg0 field mask", v, 32'hF3);
    check("R7 pad_ie two pins", pad_ie, 32'h0000_0021);
    check("R8 cfg0 override uses zero pair", pad_oe[0], 1'b0);
    wr(8'h80, 32'h0);
  endtask

  task automatic t_mux;
    logic [31:0] v;
    // pin 9 as port input driving 0
    wr(8'h04, 32'h0000_0200); dir_m &= ~32'h0000_0200;
    wr(8'h10, 32'h0000_0200); lvl_m &= ~32'h0000_0200;
    per_out[7*NPIN + 9] = 1'b1;
    per_oe[7*NPIN + 9]  = 1'b1;
    per_oe[7*NPIN + 10] = 1'b1;
    wr(8'h80 + 8'd36, 32'h0000_0072);
    check("R8 pin9 oe from func7", pad_oe[9], 1'b1);
    check("R8 pin9 out from func7", pad_out[9], 1'b1);
    check("R6 pin10 untouched oe", pad_oe[10], dir_m[10]);
    wr(8'h0C, 32'hFFFF_FFFF); lvl_m = 32'hFFFF_FFFF;
    wr(8'h00, 32'h0); dir_m = 0;
    per_out[7*NPIN + 9] = 1'b0;
    #1 check("R8 port ignored, follows periph", pad_out[9], 1'b0);
    check("R8 port dir ignored", pad_oe[9], 1'b1);
    wr(8'h80 + 8'd36, 32'h0000_0022);
    check("R8 func2 zero pair oe", pad_oe[9], 1'b0);
    wr(8'h80 + 8'd36, 32'h0000_0000);
    check("R6 override off oe", pad_oe, dir_m);
    check("R6 override off out", pad_out, lvl_m);
    rd(8'h0C, v); check("R8 lvl reg kept", v, lvl_m);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_dir;
    t_lvl;
    t_idle;
    t_cfg;
    t_mux;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule